// File: doc/BRIEF.md
# Lock-Step Odd-Even Neighbour Sort Array

This block sorts a small vector of unsigned keys with a row of identical processing elements that all obey one shared controller. Each element keeps a single key. On every clock cycle of a sort, the controller broadcasts a phase parity to the whole row. Each element whose index matches that parity compares its key with the key of its right-hand neighbour, and the two keys trade places when the left one is strictly greater. The choice between swapping and holding is a predicate applied under the common control. No element has control flow of its own.

A one-cycle start pulse copies all keys into the row at once. The controller then runs a fixed number of phases, equal to the element count. The phases alternate, and the first one is even. When the last phase is done, the controller raises done for a single cycle. The row contents are visible in parallel at all times, so they show each intermediate phase and then the sorted result.

Top module: `oddeven_sort_array`

## Requirements
- R1: After reset, busy and done are 0 and every element of sorted_vec is 0.
- R2: A start pulse while busy is 0 loads all N keys of load_vec at once. The key for element i is in bits [i*W +: W]. On the next cycle busy is 1 and sorted_vec equals load_vec.
- R3: In the first phase and every other phase after it (the even phases), each element with an even index compares its key with the key of element index+1. The two keys swap only when the left key is strictly greater. Equal keys never swap.
- R4: In the odd phases the same rule applies to odd-indexed elements only. The last element (index N-1) never starts a comparison. Elements that are not selected keep their key unless their left neighbour swaps with them.
- R5: Exactly N phases run, one per clock cycle, after the load. On the edge that completes the last phase, busy falls and done rises. Done stays high for exactly one cycle.
- R6: When done is high, sorted_vec is in non-decreasing order from element 0 up to element N-1. It holds the same multiset of keys that was loaded.
- R7: A start pulse while busy is 1 is ignored. The phase sequence, the row contents and the timing of done continue as if the pulse had not occurred.
- R8: While idle with no start pulse, sorted_vec holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Load load_vec and begin sorting when idle |
| load_vec | input | N*W | Keys to load, element i at bits [i*W +: W] |
| busy | output | 1 | High while phases are running |
| done | output | 1 | One-cycle pulse when sorting completes |
| sorted_vec | output | N*W | Current row contents, element i at bits [i*W +: W] |

## Verification
Every phase writes straight into the row that drives sorted_vec, so a fault in the parity, in a compare or in the swap steering shows up at the ports one cycle after the edge where it happens. The bench therefore compares the whole vector after every single phase, not only the final result. A fault in the phase counter moves done and the fall of busy away from the Nth cycle, and this is seen at that cycle. A start pulse that leaks in during a sort overwrites the row with different keys, so the error appears on the very next cycle.

// File: rtl/oddeven_sort_array.sv
module oddeven_sort_array #(
  parameter int N = 8,
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [N*W-1:0] load_vec,
  output logic           busy,
  output logic           done,
  output logic [N*W-1:0] sorted_vec
);
  localparam int CW = $clog2(N) + 1;

  logic [N-1:0][W-1:0] val, nxt;
  logic [N-2:0]        swp;
  logic [CW-1:0]       ph;
  logic                odd;
  logic                last_ph;

  assign odd     = ph[0];
  assign last_ph = (ph == CW'(N - 1));

  for (genvar i = 0; i < N - 1; i++) begin : g_pair
    localparam bit PAR = (i % 2) == 1;
    assign swp[i] = (odd == PAR) && (val[i] > val[i+1]);
  end

  for (genvar i = 0; i < N; i++) begin : g_pe
    if (i == 0) begin : g_first
      assign nxt[i] = swp[i] ? val[i+1] : val[i];
    end else if (i == N - 1) begin : g_last
      assign nxt[i] = swp[i-1] ? val[i-1] : val[i];
    end else begin : g_mid
      assign nxt[i] = swp[i]   ? val[i+1] :
                      swp[i-1] ? val[i-1] : val[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val  <= '0;
      ph   <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy && start) begin
        val  <= load_vec;
        ph   <= '0;
        busy <= 1'b1;
      end else if (busy) begin
        val <= nxt;
        ph  <= ph + 1'b1;
        if (last_ph) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign sorted_vec = val;

  logic ordered;
  always_comb begin
    ordered = 1'b1;
    for (int k = 0; k < N - 1; k++)
      if (val[k] > val[k+1]) ordered = 1'b0;
  end

  AST_LOAD_PARALLEL: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (busy && sorted_vec == $past(load_vec))); // R2
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R5
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy))); // R5
  AST_SORTED_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ordered); // R6
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last_ph) |=> (busy && ph == $past(ph) + 1'b1)); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(sorted_vec)); // R8
endmodule

// File: tb/oddeven_sort_array_test.sv
module oddeven_sort_array_test;
  localparam int N = 8;
  localparam int W = 16;
  localparam time CLK_PERIOD = 10ns;

  typedef logic [N-1:0][W-1:0] arr_t;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic [N*W-1:0] load_vec = '0;
  logic           busy, done;
  logic [N*W-1:0] sorted_vec;

  int checks = 0;
  int fails  = 0;

  oddeven_sort_array #(.N(N), .W(W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .load_vec(load_vec),
    .busy(busy), .done(done), .sorted_vec(sorted_vec)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [N*W-1:0] act,
                     input logic [N*W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic arr_t phase_step(input arr_t v, input bit odd_ph);
    arr_t r = v;
    for (int i = (odd_ph ? 1 : 0); i < N - 1; i += 2)
      if (v[i] > v[i+1]) begin
        r[i]   = v[i+1];
        r[i+1] = v[i];
      end
    return r;
  endfunction

  function automatic arr_t ref_sort(input arr_t v);
    arr_t r = v;
    for (int i = 1; i < N; i++)
      for (int j = i; j > 0 && r[j-1] > r[j]; j--) begin
        logic [W-1:0] t = r[j];
        r[j]   = r[j-1];
        r[j-1] = t;
      end
    return r;
  endfunction

  task automatic t_reset();
    chk(busy === 1'b0, "R1 busy", {{(N*W-1){1'b0}}, busy}, '0);
    chk(done === 1'b0, "R1 done", {{(N*W-1){1'b0}}, done}, '0);
    chk(sorted_vec === '0, "R1 vector", sorted_vec, '0);
  endtask

  task automatic run_sort(input arr_t init, input string tag, input int poke_at);
    arr_t model = init;
    logic [N*W-1:0] hold;
    @(negedge clk);
    start = 1'b1; load_vec = init;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1 && sorted_vec === init, {"R2 load ", tag}, sorted_vec, init);
    for (int p = 0; p < N; p++) begin
      if (p == poke_at) begin
        start = 1'b1; load_vec = ~init;
      end
      @(posedge clk); @(negedge clk);
      start = 1'b0;
      model = phase_step(model, p[0]);
      if (p[0]) chk(sorted_vec === model, {"R4 odd phase ", tag}, sorted_vec, model);
      else      chk(sorted_vec === model, {"R3 even phase ", tag}, sorted_vec, model);
      if (poke_at >= 0)
        chk(sorted_vec === model, {"R7 start ignored ", tag}, sorted_vec, model);
      chk(done === (p == N - 1) && busy === (p != N - 1), {"R5 done/busy timing ", tag},
          {{(N*W-2){1'b0}}, done, busy}, {{(N*W-2){1'b0}}, p == N - 1, p != N - 1});
    end
    chk(sorted_vec === ref_sort(init), {"R6 sorted ", tag}, sorted_vec, ref_sort(init));
    hold = sorted_vec;
    repeat (3) @(negedge clk);
    chk(sorted_vec === hold && done === 1'b0 && busy === 1'b0, {"R8 idle hold ", tag},
        sorted_vec, hold);
  endtask

  task automatic t_reverse();
    arr_t v;
    for (int i = 0; i < N; i++) v[i] = W'(100 - 10 * i);
    run_sort(v, "reverse", -1);
  endtask

  task automatic t_sorted();
    arr_t v;
    for (int i = 0; i < N; i++) v[i] = W'(3 * i + 1);
    run_sort(v, "presorted", -1);
  endtask

  task automatic t_equal();
    arr_t v;
    for (int i = 0; i < N; i++) v[i] = 16'h0042;
    run_sort(v, "all equal", -1);
  endtask

  task automatic t_duplicates_extremes();
    arr_t v;
    v[0] = 16'hFFFF; v[1] = 16'h0000; v[2] = 16'h0007; v[3] = 16'h0007;
    v[4] = 16'hFFFF; v[5] = 16'h0001; v[6] = 16'h8000; v[7] = 16'h0000;
    run_sort(v, "dup extremes", -1);
  endtask

  task automatic t_last_small();
    arr_t v;
    for (int i = 0; i < N - 1; i++) v[i] = W'(50 + i);
    v[N-1] = 16'h0003;
    run_sort(v, "last smallest", -1);
  endtask

  task automatic t_start_while_busy();
    arr_t v;
    for (int i = 0; i < N; i++) v[i] = W'((i * 37 + 11) % 97);
    run_sort(v, "poke", 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_reverse();
    t_sorted();
    t_equal();
    t_duplicates_extremes();
    t_last_small();
    t_start_while_busy();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule